// File: doc/BRIEF.md
# Per-Tick Performance Level Selector

This controller chooses the operating level of one processing core once per simulation tick. At each tick pulse it looks at how many input spikes were queued during the previous tick, compares that count against two programmable thresholds, and asks the voltage/frequency sequencer for the lowest level that still finishes the tick's work in time. When software signals that the tick's processing has ended, the controller sends the core back to its resting level and requests clock gating. Spikes that arrive while a tick is being processed only feed the count that the next tick pulse samples.

A mode input drops the middle level, so the core runs either at the lowest level or at the top level. A second mode input makes the resting level after completion a frequency-only idle setting on the lowest rail instead of level 1. A tick that arrives before the previous tick's work is done sets a sticky overrun flag. The new selection still goes ahead.

Top module: `perf_level_sel`

## Requirements
- R1: After reset the level request strobe, sleep request and overrun flag are 0 and the current level output reads level 1 (code 2'b01).
- R2: On a tick pulse with three-level mode, the selected level is 1 (2'b01) when count < low threshold, 2 (2'b10) when low ≤ count < high threshold, and 3 (2'b11) otherwise. The request appears with its one-cycle strobe in the cycle after the tick.
- R3: If the high threshold is below the low threshold, it is treated as equal to the low one, so level 2 is never chosen.
- R4: In two-level mode, level 2 is never requested. A count at or above the low threshold selects level 3.
- R5: On processing-done, the core is sent to level 1 and the sleep request is raised in the next cycle.
- R6: With idle-level mode enabled, processing-done sends the core to the idle code 2'b00 instead of level 1.
- R7: No request strobe is issued when the target level equals the current level.
- R8: A tick arriving while the previous tick is still unfinished sets the overrun flag. The flag stays set until the clear input is pulsed, and the new selection still takes place.
- R9: Changes of the spike count between tick pulses produce no request. Only the value present at the tick is used.
- R10: The sleep request drops in the cycle after a tick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle simulation tick pulse |
| spike_count_i | input | CW | Spikes queued during the previous tick |
| proc_done_i | input | 1 | One-cycle pulse when tick processing ends |
| thr_low_i | input | CW | Low threshold |
| thr_high_i | input | CW | High threshold |
| two_level_i | input | 1 | 1 = skip the middle level |
| idle_en_i | input | 1 | 1 = rest at idle code 2'b00 after completion |
| ovr_clear_i | input | 1 | Clears the overrun flag |
| lvl_req_o | output | 2 | Requested level code (holds the current level) |
| lvl_req_valid_o | output | 1 | One-cycle strobe marking a new request |
| sleep_req_o | output | 1 | Clock gating request |
| overrun_o | output | 1 | Sticky tick overrun flag |

## Verification
A wrong current-level register shows up at the first tick or completion that follows. It causes either a missing strobe or a strobe that repeats the level already in force, and the scoreboard reports either one one cycle after the triggering pulse. A wrong busy flag shows up as a spurious or missing overrun at the next tick. The sleep output exposes a wrong sleep state in the very next cycle. The threshold corner values (equal to low, one below high, inverted thresholds, the maximum count) are driven so that an off-by-one comparison changes the requested code.

// File: rtl/perf_level_sel.sv
module perf_level_sel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [CW-1:0] spike_count_i,
  input  logic          proc_done_i,
  input  logic [CW-1:0] thr_low_i,
  input  logic [CW-1:0] thr_high_i,
  input  logic          two_level_i,
  input  logic          idle_en_i,
  input  logic          ovr_clear_i,
  output logic [1:0]    lvl_req_o,
  output logic          lvl_req_valid_o,
  output logic          sleep_req_o,
  output logic          overrun_o
);
  localparam logic [1:0] LV_IDLE = 2'b00;
  localparam logic [1:0] LV_ONE  = 2'b01;
  localparam logic [1:0] LV_TWO  = 2'b10;
  localparam logic [1:0] LV_TOP  = 2'b11;

  logic [1:0]    cur_lvl;
  logic          busy;
  logic [CW-1:0] high_eff;
  logic [1:0]    pick;
  logic [1:0]    rest_lvl;
  logic [1:0]    target;
  logic          move;

  assign high_eff = (thr_high_i < thr_low_i) ? thr_low_i : thr_high_i;

  always_comb begin
    if (spike_count_i < thr_low_i)                   pick = LV_ONE;
    else if (!two_level_i && spike_count_i < high_eff) pick = LV_TWO;
    else                                             pick = LV_TOP;
  end

  assign rest_lvl = idle_en_i ? LV_IDLE : LV_ONE;
  assign target   = tick_i ? pick : rest_lvl;
  assign move     = (tick_i || (proc_done_i && busy)) && (target != cur_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl         <= LV_ONE;
      busy            <= 1'b0;
      lvl_req_valid_o <= 1'b0;
      sleep_req_o     <= 1'b0;
      overrun_o       <= 1'b0;
    end else begin
      lvl_req_valid_o <= move;
      if (move) cur_lvl <= target;
      if (tick_i) begin
        busy        <= 1'b1;
        sleep_req_o <= 1'b0;
      end else if (proc_done_i && busy) begin
        busy        <= 1'b0;
        sleep_req_o <= 1'b1;
      end
      if (tick_i && busy && !proc_done_i) overrun_o <= 1'b1;
      else if (ovr_clear_i)               overrun_o <= 1'b0;
    end
  end

  assign lvl_req_o = cur_lvl;

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_req_valid_o |-> $past(tick_i || proc_done_i));
  assert_strobe_changes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_req_valid_o |-> !$stable(lvl_req_o));
  assert_no_mid_two_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req_valid_o && $past(tick_i) && $past(two_level_i)) |-> lvl_req_o != LV_TWO);
  assert_rest_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req_valid_o && !$past(tick_i)) |-> (lvl_req_o == LV_IDLE || lvl_req_o == LV_ONE));
  assert_sleep_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req_o) |-> $past(proc_done_i));
  assert_wake_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_i) |-> !sleep_req_o);
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(tick_i));
endmodule

// File: tb/perf_level_sel_tb.sv
module perf_level_sel_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_i = 0;
  logic [15:0] spike_count_i = 0;
  logic        proc_done_i = 0;
  logic [15:0] thr_low_i = 16'd10;
  logic [15:0] thr_high_i = 16'd20;
  logic        two_level_i = 0;
  logic        idle_en_i = 0;
  logic        ovr_clear_i = 0;
  logic [1:0]  lvl_req_o;
  logic        lvl_req_valid_o;
  logic        sleep_req_o;
  logic        overrun_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_lvl = 2'b01;
  logic [1:0] expq[$];
  string      tagq[$];

  always #2 clk = ~clk;

  perf_level_sel dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_pick(input logic [15:0] l);
    logic [15:0] hi;
    hi = (thr_high_i < thr_low_i) ? thr_low_i : thr_high_i;
    if (l < thr_low_i) return 2'b01;
    if (two_level_i) return 2'b11;
    if (l < hi) return 2'b10;
    return 2'b11;
  endfunction

  always @(negedge clk) begin
    if (rst_n && lvl_req_valid_o) begin
      if (expq.size() == 0) chk(0, "R7 unexpected request", lvl_req_o, -1);
      else begin
        logic [1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(lvl_req_o == e, t, lvl_req_o, e);
      end
    end
  end

  task automatic do_tick(input logic [15:0] l, input string tag);
    logic [1:0] s;
    @(negedge clk);
    spike_count_i = l;
    tick_i = 1;
    s = model_pick(l);
    if (s != m_lvl) begin expq.push_back(s); tagq.push_back(tag); m_lvl = s; end
    @(negedge clk);
    tick_i = 0;
    chk(sleep_req_o == 0, "R10 sleep after tick", sleep_req_o, 0);
  endtask

  task automatic do_done(input string tag);
    logic [1:0] r;
    @(negedge clk);
    proc_done_i = 1;
    r = idle_en_i ? 2'b00 : 2'b01;
    if (r != m_lvl) begin expq.push_back(r); tagq.push_back(tag); m_lvl = r; end
    @(negedge clk);
    proc_done_i = 0;
    chk(sleep_req_o == 1, "R5 sleep after done", sleep_req_o, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lvl_req_valid_o == 0, "R1 strobe", lvl_req_valid_o, 0);
    chk(sleep_req_o == 0, "R1 sleep", sleep_req_o, 0);
    chk(overrun_o == 0, "R1 overrun", overrun_o, 0);
    chk(lvl_req_o == 2'b01, "R1 level", lvl_req_o, 1);

    do_tick(5, "R7 same level");  do_done("R5 rest");
    do_tick(10, "R2 at low");     do_done("R5 back to 1");
    do_tick(19, "R2 below high"); do_done("R5 back to 1");
    do_tick(20, "R2 at high");    do_done("R5 back to 1");
    do_tick(16'hFFFF, "R2 max");  do_done("R5 back to 1");

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      spike_count_i = 16'(i * 7000);
      chk(lvl_req_valid_o == 0, "R9 count ignored between ticks", lvl_req_valid_o, 0);
    end

    thr_high_i = 16'd5;
    do_tick(12, "R3 inverted thresholds"); do_done("R5 back to 1");
    do_tick(9, "R3 below low");            do_done("R5 rest");
    thr_high_i = 16'd20;

    two_level_i = 1;
    do_tick(15, "R4 two-level jump"); do_done("R5 back to 1");
    do_tick(10, "R4 at low");         do_done("R5 back to 1");
    two_level_i = 0;

    idle_en_i = 1;
    do_tick(15, "R2 mid"); do_done("R6 idle rest");
    do_tick(3, "R6 leave idle"); do_done("R6 idle rest");
    idle_en_i = 0;

    do_tick(15, "R8 first");
    chk(overrun_o == 0, "R8 no overrun yet", overrun_o, 0);
    do_tick(25, "R8 selection proceeds");
    chk(overrun_o == 1, "R8 overrun set", overrun_o, 1);
    repeat (3) @(negedge clk);
    chk(overrun_o == 1, "R8 overrun sticky", overrun_o, 1);
    ovr_clear_i = 1;
    @(negedge clk);
    ovr_clear_i = 0;
    chk(overrun_o == 0, "R8 overrun cleared", overrun_o, 0);
    do_done("R5 back to 1");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2 all requests seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule